// File: doc/BRIEF.md
# UART Receive FIFO with Trigger Level

This block buffers received serial characters between a receiver and the host-side register bank. Each character arrives with three status flags: parity error, framing error and break. The block holds up to sixteen characters in arrival order. It reports data-ready and error status in a line-status byte, and it raises a received-data request once occupancy reaches a host-selected threshold. A control write selects the mode and the threshold and can flush the buffer. When buffering is turned off, the block acts as a single holding register.

Characters enter over a valid/ready stream. The receiver cannot be stalled, so `in_ready` is advisory: it is high while a slot is free. A character offered while `in_ready` is low is dropped and recorded as an overrun. On the read side, `out_valid` is high while a character is held. A handshake (`out_valid` and `out_ready` both high at a clock edge) removes the head, and `out_data` then shows the next character. The line-status byte, the request line and `out_valid` all follow the state registered at the last clock edge.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset the block holds no data. `lsr_status` is 0x00, `out_valid` and `rx_irq` are low, `in_ready` is high, and the block is in single-register mode.
- R2: With `ctl_data[0]=1` written, the block holds up to 16 characters. `in_ready` is low exactly when 16 are held.
- R3: A character offered while `in_ready` is low is discarded, and the held contents are unchanged. `lsr_status[1]` (overrun) is set on the next edge.
- R4: `lsr_status[0]` and `out_valid` are high exactly while at least one character is held.
- R5: `lsr_status[2]`, `[3]` and `[4]` show the parity, framing and break flags of the character at the head.
- R6: A pulse on `lsr_rd` clears `lsr_status[1]` and hides the head's flags in bits 2 to 4 until the head is removed. A new overrun in the same cycle takes priority over the clear.
- R7: `lsr_status[7]` is high while any held character has an error flag that is not hidden.
- R8: `rx_irq` is high while the held count is at or above the threshold that `ctl_data[7:6]` selects: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R9: A control write with `ctl_data[1]=1` empties the buffer at that edge, and this clear wins over a push or pop in the same cycle. `tx_flush` is high during any control write with `ctl_data[2]=1`.
- R10: With `ctl_data[0]=0` the capacity is one character and the threshold is 1, whatever the trigger field holds.
- R11: A control write that changes `ctl_data[0]` from its current value empties the buffer.
- R12: Characters leave on the read handshake in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receiver offers a character |
| in_ready | output | 1 | A slot is free (advisory) |
| in_data | input | 8 | Received character |
| in_perr | input | 1 | Parity error flag of the character |
| in_ferr | input | 1 | Framing error flag of the character |
| in_brk | input | 1 | Break flag of the character |
| out_valid | output | 1 | A character is held |
| out_ready | input | 1 | Host takes the head character |
| out_data | output | 8 | Head character |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 8 | Control value: [0] buffer enable, [1] receive clear, [2] transmit clear, [7:6] threshold |
| tx_flush | output | 1 | Transmit clear strobe, passed through during a control write |
| lsr_rd | input | 1 | Line-status read strobe |
| lsr_status | output | 8 | Line status: [0] ready, [1] overrun, [2] parity, [3] framing, [4] break, [7] any error |
| rx_irq | output | 1 | Received-data request |

## Verification
A push, pop, control write or status read shows up at the outputs one clock edge after the cycle in which it was driven. The exception is `tx_flush`, which follows `ctl_wr` in the same cycle. The bench drives each stimulus just after a rising edge, holds it for one cycle, and samples results just after the following edge. It checks `tx_flush` while the write is still applied. Popped characters are compared at the falling edge inside the handshake cycle, against a queue that the push task fills only when the bench's own occupancy model predicts the character is accepted.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE      = 2'b00,
    TRIG_QUARTER  = 2'b01,
    TRIG_HALF     = 2'b10,
    TRIG_NEARFULL = 2'b11
  } trig_sel_e;

  localparam int unsigned LS_READY = 0;
  localparam int unsigned LS_OVR   = 1;
  localparam int unsigned LS_PAR   = 2;
  localparam int unsigned LS_FRM   = 3;
  localparam int unsigned LS_BRK   = 4;
  localparam int unsigned LS_ANY   = 7;

  localparam int unsigned CTL_EN     = 0;
  localparam int unsigned CTL_RXCLR  = 1;
  localparam int unsigned CTL_TXCLR  = 2;
  localparam int unsigned CTL_TRG_LO = 6;

  // Threshold for a given selection, scaled to the buffer depth.
  function automatic int unsigned trig_level(trig_sel_e sel, int unsigned depth);
    int unsigned lvl;
    case (sel)
      TRIG_ONE:     lvl = 1;
      TRIG_QUARTER: lvl = depth / 4;
      TRIG_HALF:    lvl = depth / 2;
      default:      lvl = (depth > 2) ? depth - 2 : depth;
    endcase
    if (lvl == 0) lvl = 1;
    return lvl;
  endfunction

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          clr,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          overrun_evt,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cap;
  logic          has_room;

  assign cap         = fifo_en ? CW'(DEPTH) : CW'(1);
  assign has_room    = (count < cap);
  assign push_ok     = push_req && has_room && !clr;
  assign overrun_evt = push_req && !has_room && !clr;
  assign pop_ok      = pop_req && (count != '0) && !clr;

  function automatic logic [PW-1:0] advance(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= advance(wr_ptr);
      if (pop_ok)  rd_ptr <= advance(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rxf_storage.sv
module rxf_storage #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned EW    = 11,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] wr_ptr,
  input  logic [EW-1:0] wdata,
  input  logic [PW-1:0] rd_ptr,
  output logic [EW-1:0] rdata
);

  logic [EW-1:0] slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slots[g] <= '0;
      else if (we && (wr_ptr == PW'(g)))
        slots[g] <= wdata;
    end
  end

  assign rdata = slots[rd_ptr];

endmodule

// File: rtl/rxf_status.sv
module rxf_status #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_ok,
  input  logic          push_err,
  input  logic          pop_ok,
  input  logic [2:0]    head_flags,
  input  logic [CW-1:0] count,
  input  logic          overrun_evt,
  input  logic          lsr_rd,
  input  logic [CW-1:0] trig_lvl,
  output logic [7:0]    lsr_status,
  output logic          rx_irq
);
  import rxf_pkg::*;

  logic          ovr_q;
  logic          hide_q;
  logic [CW-1:0] err_cnt;
  logic          nonempty;
  logic          head_err;
  logic          head_vis;
  logic [CW-1:0] other_errs;

  assign nonempty   = (count != '0);
  assign head_err   = nonempty && (|head_flags);
  assign head_vis   = nonempty && !hide_q;
  assign other_errs = err_cnt - CW'(head_err);

  // Overrun: a new overrun takes priority over the read-clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ovr_q <= 1'b0;
    else if (overrun_evt) ovr_q <= 1'b1;
    else if (lsr_rd)      ovr_q <= 1'b0;
  end

  // Head flags are hidden after a status read until the head changes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hide_q <= 1'b0;
    else if (clr || pop_ok || !nonempty) hide_q <= 1'b0;
    else if (lsr_rd)                    hide_q <= 1'b1;
  end

  // Number of held entries that carry any error flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err_cnt <= '0;
    else if (clr) err_cnt <= '0;
    else          err_cnt <= err_cnt + CW'(push_ok && push_err) - CW'(pop_ok && head_err);
  end

  always_comb begin
    lsr_status           = '0;
    lsr_status[LS_READY] = nonempty;
    lsr_status[LS_OVR]   = ovr_q;
    lsr_status[LS_PAR]   = head_vis && head_flags[0];
    lsr_status[LS_FRM]   = head_vis && head_flags[1];
    lsr_status[LS_BRK]   = head_vis && head_flags[2];
    lsr_status[LS_ANY]   = (head_vis && head_err) || (other_errs != '0);
  end

  assign rx_irq = (count >= trig_lvl);

endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_perr,
  input  logic              in_ferr,
  input  logic              in_brk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_data,
  output logic              tx_flush,
  input  logic              lsr_rd,
  output logic [7:0]        lsr_status,
  output logic              rx_irq
);
  import rxf_pkg::*;

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned EW = DATA_W + 3;

  logic          fifo_en_q;
  trig_sel_e     trig_sel_q;
  logic          clr;
  logic          push_ok, pop_ok, overrun_evt;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [CW-1:0] trig_lvl;
  logic [EW-1:0] wdata, rdata;

  // Control register: mode and threshold; clear strobes are not stored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q  <= 1'b0;
      trig_sel_q <= TRIG_ONE;
    end else if (ctl_wr) begin
      fifo_en_q  <= ctl_data[CTL_EN];
      trig_sel_q <= trig_sel_e'(ctl_data[CTL_TRG_LO +: 2]);
    end
  end

  assign clr      = ctl_wr && (ctl_data[CTL_RXCLR] || (ctl_data[CTL_EN] != fifo_en_q));
  assign tx_flush = ctl_wr && ctl_data[CTL_TXCLR];
  assign trig_lvl = fifo_en_q ? CW'(trig_level(trig_sel_q, DEPTH)) : CW'(1);

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en_q),
    .clr         (clr),
    .push_req    (in_valid),
    .pop_req     (out_ready),
    .push_ok     (push_ok),
    .pop_ok      (pop_ok),
    .overrun_evt (overrun_evt),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .count       (count)
  );

  assign wdata = {in_brk, in_ferr, in_perr, in_data};

  rxf_storage #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (push_ok),
    .wr_ptr (wr_ptr),
    .wdata  (wdata),
    .rd_ptr (rd_ptr),
    .rdata  (rdata)
  );

  rxf_status #(.DEPTH(DEPTH)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .push_ok     (push_ok),
    .push_err    (in_perr || in_ferr || in_brk),
    .pop_ok      (pop_ok),
    .head_flags  (rdata[EW-1 -: 3]),
    .count       (count),
    .overrun_evt (overrun_evt),
    .lsr_rd      (lsr_rd),
    .trig_lvl    (trig_lvl),
    .lsr_status  (lsr_status),
    .rx_irq      (rx_irq)
  );

  assign out_data  = rdata[DATA_W-1:0];
  assign out_valid = (count != '0);
  assign in_ready  = fifo_en_q ? (count < CW'(DEPTH)) : (count == '0);

endmodule

// File: rtl/rx_fifo_trig_checker.sv
module rxf_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          ctl_wr,
  input logic [7:0]    ctl_data,
  input logic          lsr_rd,
  input logic [7:0]    lsr_status,
  input logic          rx_irq,
  input logic          fifo_en,
  input logic [CW-1:0] count
);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_overrun_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !ctl_wr) |=> lsr_status[1]);

  assert_push_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !ctl_wr) |=> (out_valid && lsr_status[0]));

  assert_read_clears_ovr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !(in_valid && !in_ready)) |=> !lsr_status[1]);

  assert_irq_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> out_valid);

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_data[1]) |=> !out_valid);

  assert_single_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && out_valid) |-> !in_ready);

endmodule

bind rx_fifo_trig rxf_checker #(.DEPTH(DEPTH)) u_rxf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .ctl_wr     (ctl_wr),
  .ctl_data   (ctl_data),
  .lsr_rd     (lsr_rd),
  .lsr_status (lsr_status),
  .rx_irq     (rx_irq),
  .fifo_en    (fifo_en_q),
  .count      (count)
);

// File: tb/rx_fifo_trig_bench.sv
`timescale 1ns/1ps
module rx_fifo_trig_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_perr = 1'b0, in_ferr = 1'b0, in_brk = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, tx_flush, rx_irq;
  logic       out_ready = 1'b0, ctl_wr = 1'b0, lsr_rd = 1'b0;
  logic [7:0] ctl_data = '0, out_data, lsr_status;

  int checks = 0, fails = 0;
  byte unsigned sb[$];
  int mcnt = 0, mdepth = 1;
  bit men = 1'b0;

  always #5 clk = ~clk;

  rx_fifo_trig u_rx_fifo_trig (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_perr(in_perr), .in_ferr(in_ferr), .in_brk(in_brk),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ctl_wr(ctl_wr), .ctl_data(ctl_data), .tx_flush(tx_flush),
    .lsr_rd(lsr_rd), .lsr_status(lsr_status), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  // Driver: offers one character; the scoreboard takes it only if the model has room.
  task automatic push(input byte unsigned d, input bit p, input bit f, input bit b);
    in_valid = 1'b1; in_data = d; in_perr = p; in_ferr = f; in_brk = b;
    if (mcnt < mdepth) begin sb.push_back(d); mcnt++; end
    cyc();
    in_valid = 1'b0; in_perr = 1'b0; in_ferr = 1'b0; in_brk = 1'b0;
  endtask

  task automatic pop1();
    out_ready = 1'b1;
    cyc();
    out_ready = 1'b0;
    if (mcnt > 0) mcnt--;
  endtask

  task automatic ctl(input byte unsigned v);
    ctl_wr = 1'b1; ctl_data = v;
    #1;
    chk(tx_flush == v[2], "R9 tx_flush", tx_flush, v[2]);
    cyc();
    ctl_wr = 1'b0;
    if (v[1] || (v[0] != men)) begin sb.delete(); mcnt = 0; end
    men = v[0];
    mdepth = men ? 16 : 1;
  endtask

  task automatic status_read();
    lsr_rd = 1'b1;
    cyc();
    lsr_rd = 1'b0;
  endtask

  // Monitor: compares each popped character with the scoreboard head (R12).
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) chk(1'b0, "R12 unexpected pop", out_data, 0);
      else begin
        chk(out_data == sb[0], "R12 order", out_data, sb[0]);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk(lsr_status == 8'h00, "R1 lsr", lsr_status, 8'h00);
    chk(!out_valid && !rx_irq && in_ready, "R1 flags", {out_valid, rx_irq, in_ready}, 3'b001);

    // R10 single-register mode
    push(8'hA1, 0, 0, 0);
    chk(out_valid && lsr_status[0], "R4 ready set", lsr_status, 8'h01);
    chk(rx_irq == 1'b1, "R10 trigger one", rx_irq, 1);
    chk(in_ready == 1'b0, "R10 depth one", in_ready, 0);
    push(8'hA2, 0, 0, 0);
    chk(lsr_status == 8'h03, "R3 overrun", lsr_status, 8'h03);
    chk(out_data == 8'hA1, "R3 contents kept", out_data, 8'hA1);
    pop1();
    chk(!out_valid && lsr_status == 8'h02, "R4 ready clear", lsr_status, 8'h02);
    status_read();
    chk(lsr_status == 8'h00, "R6 overrun cleared", lsr_status, 8'h00);

    // FIFO mode, threshold 4
    ctl(8'h41);
    for (int i = 0; i < 3; i++) push(8'h10 + 8'(i), 0, 0, 0);
    chk(rx_irq == 1'b0, "R8 below 4", rx_irq, 0);
    push(8'h13, 0, 0, 0);
    chk(rx_irq == 1'b1, "R8 at 4", rx_irq, 1);
    pop1();
    chk(rx_irq == 1'b0, "R8 back below 4", rx_irq, 0);

    // threshold 8, fill to 16
    ctl(8'h81);
    push(8'h14, 1, 0, 0);
    push(8'h15, 0, 1, 1);
    for (int i = 0; i < 11; i++) push(8'h16 + 8'(i), 0, 0, 0);
    chk(in_ready == 1'b0, "R2 full", in_ready, 0);
    chk(rx_irq == 1'b1, "R8 at 8", rx_irq, 1);
    chk(lsr_status == 8'h81, "R7 error behind head", lsr_status, 8'h81);
    push(8'h99, 0, 0, 0);
    chk(lsr_status == 8'h83, "R3 overrun when full", lsr_status, 8'h83);

    // threshold 14
    ctl(8'hC1);
    chk(rx_irq == 1'b1, "R8 16 vs 14", rx_irq, 1);
    for (int i = 0; i < 3; i++) pop1();
    chk(rx_irq == 1'b0, "R8 13 vs 14", rx_irq, 0);
    chk(lsr_status == 8'h87, "R5 parity head", lsr_status, 8'h87);
    status_read();
    chk(lsr_status == 8'h81, "R6 head hidden", lsr_status, 8'h81);
    pop1();
    chk(lsr_status == 8'h99, "R5 framing break head", lsr_status, 8'h99);
    status_read();
    chk(lsr_status == 8'h01, "R7 all hidden", lsr_status, 8'h01);
    pop1();
    chk(out_valid == 1'b1, "R12 still data", out_valid, 1);

    // clear strobe with transmit clear
    ctl(8'hC7);
    chk(!out_valid && lsr_status == 8'h00, "R9 cleared", lsr_status, 8'h00);
    chk(in_ready == 1'b1, "R9 room", in_ready, 1);

    // mode change flushes
    push(8'h30, 0, 0, 0);
    push(8'h31, 0, 0, 0);
    chk(out_valid == 1'b1, "R2 held two", out_valid, 1);
    ctl(8'h00);
    chk(out_valid == 1'b0, "R11 flush on mode change", out_valid, 0);
    push(8'h40, 0, 0, 0);
    pop1();

    // clear wins over a push in the same cycle
    ctl_wr = 1'b1; ctl_data = 8'h02; in_valid = 1'b1; in_data = 8'h55;
    cyc();
    ctl_wr = 1'b0; in_valid = 1'b0;
    chk(out_valid == 1'b0, "R9 clear beats push", out_valid, 0);
    chk(sb.size() == 0, "R12 scoreboard drained", sb.size(), 0);

    summary();
  end

endmodule